// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces the digital timing for one horizontal line of an interline CCD whose horizontal register moves charge with two phases. A master clock runs at `SUBDIV` times the pixel rate. From it the block derives three kinds of output. The first kind drives the register: two complementary transfer phases and a reset-gate pulse once per pixel. The second kind serves correlated double sampling: a reference-level strobe and, later in the same pixel, a data-level strobe. The third kind marks where each pixel falls in the line: flags for dummy bits, leading and trailing optical black, the ignored guard pixels and the active pixels, and a window near the start of the line in which the vertical sequencer may move its phases.

A normal line is 2669 pixel periods long. The register clocks, the reset gate and the strobes run without a break through blanking and idle periods. Only the position flags depend on the pixel count. The vertical sequencer marks the end of a frame with a one-cycle `last_line` pulse. The line that starts after the pulse is shortened to 1672 pixels for 60 Hz timing or 464 pixels for 50 Hz timing, as chosen by `pal_sel`. The next line returns to full length. A `line_start` pulse on the first clock of each line lets the sequencer step its line counter.

Top module: `ccd_hline_timing`

## Requirements
- R1: While reset is held, the outputs are: `line_start`=1, `h1`=1, `h2`=0, `rg`=1, `samp_ref`=0, `samp_data`=0, `vxfer_win`=1, all five position flags 0. This is the state of the first clock of pixel 1.
- R2: A pixel period is 4 master clocks, with sub-steps 0 to 3. `h1` is high in sub-steps 0 and 1 and low in 2 and 3. `h2` is the complement of `h1` on every clock.
- R3: `rg` is high for exactly one clock, sub-step 0, in every pixel, including blanking and idle pixels.
- R4: `samp_ref` is high only in sub-step 1 and `samp_data` only in sub-step 3. Each is one clock wide, so the reference strobe precedes the data strobe in every pixel.
- R5: `line_start` is high only on the first clock of pixel 1 of each line.
- R6: A line that is not shortened lasts 2669 pixels, which is 10676 clocks.
- R7: The position flags, by pixel number (1-based), are:
  - `win_dummy`: 250 to 277.
  - `win_ob_front`: 278 to 293.
  - `win_ignored`: 294 to 295 and 2608 to 2609.
  - `win_active`: 296 to 2607.
  - `win_ob_rear`: 2610 to 2665.
  
  No flag is high outside these ranges, and at most one flag is high at a time.
- R8: `vxfer_win` is high exactly in pixels 1 to 364.
- R9: After a `last_line` pulse, the next line that starts lasts 1672 pixels if `pal_sel`=0 or 464 pixels if `pal_sel`=1. Only that one line is shortened.
- R10: `pal_sel` and a pending `last_line` request are sampled only on the final clock of a line. A pulse that falls on that clock shortens the line that starts immediately after it. Changing `pal_sel` during a line does not change that line's length.
- R11: Several `last_line` pulses within one line shorten only one following line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, SUBDIV times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal_sel | input | 1 | 0: 60 Hz short-line length, 1: 50 Hz short-line length |
| last_line | input | 1 | One-cycle pulse from the vertical sequencer marking the frame's final line |
| h1 | output | 1 | Horizontal transfer phase 1 |
| h2 | output | 1 | Horizontal transfer phase 2, complement of h1 |
| rg | output | 1 | Reset-gate pulse, once per pixel |
| samp_ref | output | 1 | Reference-level sample strobe |
| samp_data | output | 1 | Data-level sample strobe |
| line_start | output | 1 | First clock of each line |
| vxfer_win | output | 1 | Window in which vertical transfer may occur |
| win_dummy | output | 1 | Dummy-bit pixels |
| win_ob_front | output | 1 | Leading optical-black pixels |
| win_ignored | output | 1 | Guard pixels on both sides of the active region |
| win_active | output | 1 | Active (effective) pixels |
| win_ob_rear | output | 1 | Trailing optical-black pixels |

## Verification
The assertions take for granted that the clock never stops and that `last_line` and `pal_sel` may change on any clock. A line-length assertion therefore accepts any of the three legal lengths and does not predict which one comes next. The stimulus exercises these freedoms in several ways:
- Directed steps toggle `pal_sel` in the middle of lines.
- A `last_line` pulse is placed on the exact final clock of a line.
- Several pulses are fired within one line.
- A random phase with a fixed seed sprinkles both inputs at arbitrary positions, including inside shortened lines.

// File: rtl/ccd_htg_pkg.sv
package ccd_htg_pkg;

   // Order of the position regions along a line.
   typedef enum int {
      RGN_DUMMY     = 0,
      RGN_OBF       = 1,
      RGN_IGN_LEAD  = 2,
      RGN_ACT       = 3,
      RGN_IGN_TRAIL = 4,
      RGN_OBR       = 5
   } rgn_e;

   localparam int RGN_N = 6;

   // Per-clock register and sampling controls.
   typedef struct packed {
      logic h1;
      logic h2;
      logic rg;
      logic s_ref;
      logic s_dat;
   } hclk_t;

endpackage

// File: rtl/ccd_htg_counter.sv
module ccd_htg_counter #(
   parameter int SUBDIV     = 4,
   parameter int LINE_PIX   = 2669,
   parameter int SHORT_NTSC = 1672,
   parameter int SHORT_PAL  = 464,
   parameter int PIX_W      = 12,
   parameter int SUB_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pal_sel,
   input  logic             last_line,
   output logic [PIX_W-1:0] pix,
   output logic [SUB_W-1:0] sub
);

   logic [PIX_W-1:0] len_q;
   logic             arm_q;
   logic             pix_end;
   logic             line_end;

   assign pix_end  = (sub == SUB_W'(SUBDIV - 1));
   assign line_end = pix_end && (pix == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix   <= PIX_W'(1);
         sub   <= '0;
         len_q <= PIX_W'(LINE_PIX);
         arm_q <= 1'b0;
      end else begin
         sub <= pix_end ? '0 : sub + SUB_W'(1);
         if (line_end) begin
            pix   <= PIX_W'(1);
            arm_q <= 1'b0;
            if (arm_q || last_line)
               len_q <= pal_sel ? PIX_W'(SHORT_PAL) : PIX_W'(SHORT_NTSC);
            else
               len_q <= PIX_W'(LINE_PIX);
         end else begin
            if (pix_end)   pix   <= pix + PIX_W'(1);
            if (last_line) arm_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ccd_htg_phase.sv
module ccd_htg_phase
   import ccd_htg_pkg::*;
#(
   parameter int SUBDIV   = 4,
   parameter int SUB_W    = 2,
   parameter bit H1_FIRST = 1'b1
) (
   input  logic [SUB_W-1:0] sub,
   output hclk_t            hc
);

   localparam int HALF = SUBDIV / 2;

   logic first_half;
   assign first_half = (sub < SUB_W'(HALF));

   generate
      if (H1_FIRST) begin : g_h1_lead
         assign hc.h1 = first_half;
      end else begin : g_h2_lead
         assign hc.h1 = !first_half;
      end
   endgenerate

   assign hc.h2    = !hc.h1;
   assign hc.rg    = (sub == '0);
   assign hc.s_ref = (sub == SUB_W'(1));
   assign hc.s_dat = (sub == SUB_W'(SUBDIV - 1));

endmodule

// File: rtl/ccd_htg_window.sv
module ccd_htg_window
   import ccd_htg_pkg::*;
#(
   parameter int PIX_W      = 12,
   parameter int BLANK_PIX  = 364,
   parameter int READ_START = 250,
   parameter int DUMMY_PIX  = 28,
   parameter int OBF_PIX    = 16,
   parameter int IGN_PIX    = 2,
   parameter int ACT_PIX    = 2312,
   parameter int OBR_PIX    = 56
) (
   input  logic [PIX_W-1:0] pix,
   output logic             vxfer_win,
   output logic             win_dummy,
   output logic             win_ob_front,
   output logic             win_ignored,
   output logic             win_active,
   output logic             win_ob_rear
);

   localparam int BND [0:RGN_N] = '{
      READ_START,
      READ_START + DUMMY_PIX,
      READ_START + DUMMY_PIX + OBF_PIX,
      READ_START + DUMMY_PIX + OBF_PIX + IGN_PIX,
      READ_START + DUMMY_PIX + OBF_PIX + IGN_PIX + ACT_PIX,
      READ_START + DUMMY_PIX + OBF_PIX + 2*IGN_PIX + ACT_PIX,
      READ_START + DUMMY_PIX + OBF_PIX + 2*IGN_PIX + ACT_PIX + OBR_PIX
   };

   logic [RGN_N-1:0] in_rng;

   generate
      for (genvar i = 0; i < RGN_N; i++) begin : g_rgn
         assign in_rng[i] = (pix >= PIX_W'(BND[i])) && (pix < PIX_W'(BND[i+1]));
      end
   endgenerate

   assign vxfer_win    = (pix <= PIX_W'(BLANK_PIX));
   assign win_dummy    = in_rng[int'(RGN_DUMMY)];
   assign win_ob_front = in_rng[int'(RGN_OBF)];
   assign win_ignored  = in_rng[int'(RGN_IGN_LEAD)] | in_rng[int'(RGN_IGN_TRAIL)];
   assign win_active   = in_rng[int'(RGN_ACT)];
   assign win_ob_rear  = in_rng[int'(RGN_OBR)];

endmodule

// File: rtl/ccd_hline_timing.sv
module ccd_hline_timing
   import ccd_htg_pkg::*;
#(
   parameter int SUBDIV     = 4,
   parameter int LINE_PIX   = 2669,
   parameter int SHORT_NTSC = 1672,
   parameter int SHORT_PAL  = 464,
   parameter int BLANK_PIX  = 364,
   parameter int READ_START = 250,
   parameter int DUMMY_PIX  = 28,
   parameter int OBF_PIX    = 16,
   parameter int IGN_PIX    = 2,
   parameter int ACT_PIX    = 2312,
   parameter int OBR_PIX    = 56,
   parameter bit H1_FIRST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pal_sel,
   input  logic last_line,
   output logic h1,
   output logic h2,
   output logic rg,
   output logic samp_ref,
   output logic samp_data,
   output logic line_start,
   output logic vxfer_win,
   output logic win_dummy,
   output logic win_ob_front,
   output logic win_ignored,
   output logic win_active,
   output logic win_ob_rear
);

   localparam int PIX_W    = $clog2(LINE_PIX + 1);
   localparam int SUB_W    = $clog2(SUBDIV);
   localparam int READ_END = READ_START + DUMMY_PIX + OBF_PIX + 2*IGN_PIX
                             + ACT_PIX + OBR_PIX - 1;

   // Elaboration-time parameter checks
   generate
      if (SUBDIV < 4 || (1 << SUB_W) != SUBDIV) begin : g_bad_subdiv
         $error("SUBDIV must be a power of two of at least 4");
      end
      if (READ_END > LINE_PIX) begin : g_bad_layout
         $error("readout regions exceed the line length");
      end
      if (SHORT_NTSC > LINE_PIX || SHORT_PAL > LINE_PIX || SHORT_PAL < 1 || SHORT_NTSC < 1) begin : g_bad_short
         $error("short line lengths must lie in 1..LINE_PIX");
      end
      if (BLANK_PIX < 1 || BLANK_PIX > LINE_PIX) begin : g_bad_blank
         $error("blanking window out of range");
      end
   endgenerate

   logic [PIX_W-1:0] pix;
   logic [SUB_W-1:0] sub;
   hclk_t            hc;

   ccd_htg_counter #(
      .SUBDIV(SUBDIV), .LINE_PIX(LINE_PIX), .SHORT_NTSC(SHORT_NTSC),
      .SHORT_PAL(SHORT_PAL), .PIX_W(PIX_W), .SUB_W(SUB_W)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .last_line(last_line),
      .pix(pix), .sub(sub)
   );

   ccd_htg_phase #(
      .SUBDIV(SUBDIV), .SUB_W(SUB_W), .H1_FIRST(H1_FIRST)
   ) u_phase (
      .sub(sub), .hc(hc)
   );

   ccd_htg_window #(
      .PIX_W(PIX_W), .BLANK_PIX(BLANK_PIX), .READ_START(READ_START),
      .DUMMY_PIX(DUMMY_PIX), .OBF_PIX(OBF_PIX), .IGN_PIX(IGN_PIX),
      .ACT_PIX(ACT_PIX), .OBR_PIX(OBR_PIX)
   ) u_win (
      .pix(pix), .vxfer_win(vxfer_win), .win_dummy(win_dummy),
      .win_ob_front(win_ob_front), .win_ignored(win_ignored),
      .win_active(win_active), .win_ob_rear(win_ob_rear)
   );

   assign h1         = hc.h1;
   assign h2         = hc.h2;
   assign rg         = hc.rg;
   assign samp_ref   = hc.s_ref;
   assign samp_data  = hc.s_dat;
   assign line_start = (pix == PIX_W'(1)) && (sub == '0);

endmodule

// File: rtl/ccd_hline_timing_chk.sv
module ccd_hline_timing_chk #(
   parameter int SUBDIV     = 4,
   parameter int LINE_PIX   = 2669,
   parameter int SHORT_NTSC = 1672,
   parameter int SHORT_PAL  = 464,
   parameter bit H1_FIRST   = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic h1,
   input logic h2,
   input logic rg,
   input logic samp_ref,
   input logic samp_data,
   input logic line_start,
   input logic vxfer_win,
   input logic win_dummy,
   input logic win_ob_front,
   input logic win_ignored,
   input logic win_active,
   input logic win_ob_rear
);

   int   clk_since;
   logic seen;
   logic lead;

   assign lead = H1_FIRST ? h1 : h2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_since <= 1;
         seen      <= 1'b0;
      end else begin
         seen      <= 1'b1;
         clk_since <= line_start ? 1 : clk_since + 1;
      end
   end

   // R2/R3: the leading phase rises with the reset-gate pulse
   assert_lead_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lead) |-> rg);

   // R2: phases never both high
   assert_no_phase_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(h1 && h2));

   // R4: reference strobe follows the reset gate by one clock
   assert_ref_after_rg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rg |=> samp_ref);

   // R4: reference strobe is one clock wide
   assert_ref_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      samp_ref |=> !samp_ref);

   // R3: next pixel's reset gate follows the data strobe
   assert_rg_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      samp_data |=> rg);

   // R7: position flags exclusive
   assert_win_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win_dummy, win_ob_front, win_ignored, win_active, win_ob_rear}));

   // R8: each line opens inside the vertical-transfer window
   assert_start_in_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> vxfer_win);

   // R5: line start falls on a reset-gate clock
   assert_start_on_rg_R5: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |-> rg);

   // R6/R9: line lengths are legal
   assert_line_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && seen) |-> (clk_since == LINE_PIX*SUBDIV ||
                                clk_since == SHORT_NTSC*SUBDIV ||
                                clk_since == SHORT_PAL*SUBDIV));

   assert_line_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clk_since <= LINE_PIX*SUBDIV);

endmodule

bind ccd_hline_timing ccd_hline_timing_chk #(
   .SUBDIV(SUBDIV), .LINE_PIX(LINE_PIX), .SHORT_NTSC(SHORT_NTSC),
   .SHORT_PAL(SHORT_PAL), .H1_FIRST(H1_FIRST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .h1(h1), .h2(h2), .rg(rg),
   .samp_ref(samp_ref), .samp_data(samp_data), .line_start(line_start),
   .vxfer_win(vxfer_win), .win_dummy(win_dummy), .win_ob_front(win_ob_front),
   .win_ignored(win_ignored), .win_active(win_active), .win_ob_rear(win_ob_rear)
);

// File: tb/sim_ccd_hline_timing.sv
module sim_ccd_hline_timing;

   localparam int CLK_NS = 10;
   localparam int S      = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pal_sel = 1'b0;
   logic last_line = 1'b0;
   logic h1, h2, rg, samp_ref, samp_data, line_start, vxfer_win;
   logic win_dummy, win_ob_front, win_ignored, win_active, win_ob_rear;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference model state
   int m_pix = 1, m_sub = 0, m_len = 2669;
   bit m_arm = 1'b0;
   int nclk = 0;
   int prev_start = 0;
   int line_exp = 2669;
   int lens [0:63];
   int n_lines = 0;

   always #(CLK_NS/2) clk = ~clk;

   ccd_hline_timing u0 (
      .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .last_line(last_line),
      .h1(h1), .h2(h2), .rg(rg), .samp_ref(samp_ref), .samp_data(samp_data),
      .line_start(line_start), .vxfer_win(vxfer_win), .win_dummy(win_dummy),
      .win_ob_front(win_ob_front), .win_ignored(win_ignored),
      .win_active(win_active), .win_ob_rear(win_ob_rear)
   );

   function automatic logic [4:0] exp_win(int p);
      exp_win[4] = (p >= 250  && p <= 277);
      exp_win[3] = (p >= 278  && p <= 293);
      exp_win[2] = (p >= 294  && p <= 295) || (p >= 2608 && p <= 2609);
      exp_win[1] = (p >= 296  && p <= 2607);
      exp_win[0] = (p >= 2610 && p <= 2665);
   endfunction

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at clk %0d pix %0d sub %0d: actual %0h expected %0h",
                  tag, nclk, m_pix, m_sub, act, exp);
      end
   endtask

   task automatic compare(bit in_reset);
      logic exp_h1;
      exp_h1 = (m_sub < S/2);
      check(in_reset ? "R1" : "R2", {h1, h2}, {exp_h1, !exp_h1});
      check(in_reset ? "R1" : "R3", rg, m_sub == 0);
      check(in_reset ? "R1" : "R4", {samp_ref, samp_data}, {m_sub == 1, m_sub == S-1});
      check(in_reset ? "R1" : "R5", line_start, (m_pix == 1 && m_sub == 0));
      check(in_reset ? "R1" : "R8", vxfer_win, m_pix <= 364);
      check(in_reset ? "R1" : "R7",
            {win_dummy, win_ob_front, win_ignored, win_active, win_ob_rear},
            exp_win(m_pix));
      check("R7", $countones({win_dummy, win_ob_front, win_ignored, win_active, win_ob_rear}) <= 1, 1);
      if (!in_reset && line_start) begin
         // R6/R9: measured length of the line that just ended
         check(line_exp == 2669 ? "R6" : "R9", nclk - prev_start, line_exp * S);
         if (n_lines < 64) lens[n_lines] = nclk - prev_start;
         n_lines++;
         prev_start = nclk;
      end
      if (m_pix == 1 && m_sub == 0) line_exp = m_len;
   endtask

   // one clock: drive inputs, advance model, compare at the falling edge
   task automatic tick(bit ll, bit pal);
      last_line = ll;
      pal_sel   = pal;
      @(posedge clk);
      if (m_sub == S-1 && m_pix == m_len) begin
         m_pix = 1;
         m_sub = 0;
         m_len = (m_arm || ll) ? (pal ? 464 : 1672) : 2669;
         m_arm = 1'b0;
      end else begin
         if (ll) m_arm = 1'b1;
         if (m_sub == S-1) begin
            m_sub = 0;
            m_pix++;
         end else m_sub++;
      end
      nclk++;
      @(negedge clk);
      compare(1'b0);
   endtask

   task automatic run_to(int pix, bit pal);
      while (!(m_pix == pix && m_sub == 0)) tick(1'b0, pal);
   endtask

   task automatic run_to_final(bit pal);
      while (!(m_pix == m_len && m_sub == S-1)) tick(1'b0, pal);
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      void'($urandom(32'h1D0C_5EED));
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare(1'b1);               // R1 reset state
      rst_n = 1'b1;

      // line 0: pulse mid-line at 60 Hz -> line 1 short (R9)
      run_to(100, 1'b0);
      tick(1'b1, 1'b0);
      run_to_final(1'b0);
      tick(1'b0, 1'b0);
      // line 1: change pal_sel mid-line, length must stay 1672 (R10)
      run_to(800, 1'b0);
      run_to_final(1'b1);
      tick(1'b0, 1'b1);
      // line 2: full length; pulse on its final clock at 50 Hz (R10)
      run_to_final(1'b1);
      tick(1'b1, 1'b1);
      // line 3: 464 long; two pulses, then back to 60 Hz (R11)
      run_to(50, 1'b1);
      tick(1'b1, 1'b1);
      run_to(60, 1'b1);
      tick(1'b1, 1'b1);
      run_to(300, 1'b0);
      run_to_final(1'b0);
      tick(1'b0, 1'b0);
      // line 4 short 1672, line 5 full (R11)
      run_to_final(1'b0);
      tick(1'b0, 1'b0);
      run_to_final(1'b0);
      tick(1'b0, 1'b0);

      check("R9",  lens[1], 1672 * S);
      check("R6",  lens[2], 2669 * S);
      check("R10", lens[3], 464 * S);
      check("R11", lens[4], 1672 * S);
      check("R11", lens[5], 2669 * S);

      // constrained random phase
      begin
         bit pal_r;
         pal_r = 1'b0;
         for (int i = 0; i < 40000; i++) begin
            bit ll_r;
            if ($urandom_range(2999, 0) == 0) pal_r = !pal_r;
            ll_r = ($urandom_range(8999, 0) == 0);
            tick(ll_r, pal_r);
         end
      end
      done = 1'b1;
      report();
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

endmodule